// File: doc/BRIEF.md
# Configurable Universal Register Cell

This block is one storage cell whose features are chosen by parameters. It can be a plain edge-triggered register, or a register with a clock enable, a synchronous reset, an asynchronous whole-register reset, an asynchronous load, or per-bit asynchronous set and clear. Without a clock it becomes a level-sensitive latch, and with no feature at all it is a straight wire. Each control has its own polarity parameter. The power-up value, the asynchronous reset value and the synchronous reset value are parameters too. A further parameter decides whether the clock enable also gates the synchronous reset.

The controls act in a fixed order of precedence. Per-bit clear comes first, then per-bit set, then the whole-register asynchronous reset, then the asynchronous load, and last the clocked path. On the clocked path, the enable and the synchronous reset resolve against each other as the priority parameter selects. Some feature mixes are illegal, and these stop elaboration with an error. At most one kind of reset may be present (synchronous, asynchronous, or per-bit set/clear). A clocked cell with asynchronous load may carry no reset of any kind. Enable and synchronous reset each need the clock. The cell has no data stream, so every pin is a plain level or edge input with no handshake.

Top module: `ureg_cell`

## Requirements
- R1: Before any control acts or any active edge arrives, q_o equals the INIT_VAL parameter.
- R2: While bit b of clr_i is active, q_o[b] is 0. This holds even when set_i[b] is active too. The bit keeps 0 after the clear is released, until something else writes it.
- R3: While bit b of set_i is active and its clear is not, q_o[b] is 1. Only the selected bits change.
- R4: While arst_i is active, q_o equals ARST_VAL. This overrides the asynchronous load and the clock. The value is kept after release, up to the next write.
- R5: While aload_i is active and no reset of higher rank is active, q_o equals ad_i. In a cell without a clock, q_o follows ad_i as a transparent latch and holds once the load goes inactive.
- R6: On the active clock edge (rising when POL_CLK is 1, falling when 0), if no asynchronous control is active, q_o takes d_i.
- R7: With a clock enable present, an active edge with en_i inactive leaves q_o unchanged.
- R8: With CE_OVER_SRST = 0, an active edge with srst_i active loads SRST_VAL, whatever the state of en_i.
- R9: With CE_OVER_SRST = 1, an active edge with en_i inactive leaves q_o unchanged even if srst_i is active. With en_i active and srst_i active, the edge loads SRST_VAL.
- R10: Setting a control's POL_ parameter to 0 makes that control active low. A clock with POL_CLK = 0 acts on its falling edge.
- R11: With only the asynchronous reset feature (no clock, no load), q_o becomes ARST_VAL while arst_i is active. It keeps that value after release and ignores d_i.
- R12: With no feature enabled, q_o equals d_i at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; active edge chosen by POL_CLK |
| en_i | input | 1 | Clock enable |
| d_i | input | WIDTH | Synchronous data |
| aload_i | input | 1 | Asynchronous load enable (latch gate) |
| ad_i | input | WIDTH | Asynchronous load data |
| arst_i | input | 1 | Asynchronous whole-register reset |
| srst_i | input | 1 | Synchronous whole-register reset |
| set_i | input | WIDTH | Per-bit asynchronous set |
| clr_i | input | WIDTH | Per-bit asynchronous clear |
| q_o | output | WIDTH | Stored value |

## Verification
The hardest case to reach from the pins is several controls acting at once on the same bits. One example is a clear and a set overlapping while a clock edge also tries to capture new data. Another is a reset held across an edge while a load is also active. The stimulus drives all eight configurations from one shared set of logical inputs, in steps that stack these controls on top of each other. It then releases them in a safe order, set before clear and reset before load, so the value left behind shows which control won. Active-low and falling-edge variants receive the inverted signals. This lets the same step check R10 without a separate sequence.

// File: rtl/ureg_pkg.sv
package ureg_pkg;

  typedef enum logic [2:0] {
    K_WIRE,
    K_FLOP,
    K_FLOP_AR,
    K_FLOP_AL,
    K_FLOP_SR,
    K_LATCH
  } store_kind_e;

  // Legal feature mixes: one reset kind at most, no reset with clock+load,
  // enable and sync reset only with a clock.
  function automatic bit cfg_legal(bit clk, bit ce, bit srst, bit arst, bit aload, bit sr);
    int n_rst;
    n_rst = int'(srst) + int'(arst) + int'(sr);
    if (n_rst > 1) return 1'b0;
    if (clk && aload && n_rst != 0) return 1'b0;
    if ((ce || srst) && !clk) return 1'b0;
    return 1'b1;
  endfunction

  function automatic store_kind_e pick_kind(bit clk, bit arst, bit aload, bit sr);
    if (clk) begin
      if (arst)  return K_FLOP_AR;
      if (aload) return K_FLOP_AL;
      if (sr)    return K_FLOP_SR;
      return K_FLOP;
    end
    if (arst || aload || sr) return K_LATCH;
    return K_WIRE;
  endfunction

endpackage

// File: rtl/ureg_pol.sv
module ureg_pol #(
  parameter int W        = 1,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] act_o
);
  if (ACT_HIGH) begin : g_pass
    assign act_o = raw_i;
  end else begin : g_inv
    assign act_o = ~raw_i;
  end
endmodule

// File: rtl/ureg_next.sv
module ureg_next #(
  parameter int            W            = 8,
  parameter bit            HAS_CE       = 1'b1,
  parameter bit            HAS_SRST     = 1'b0,
  parameter bit            CE_OVER_SRST = 1'b0,
  parameter logic [W-1:0]  SRST_VAL     = '0
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  input  logic         srst_i,
  output logic [W-1:0] nxt_o
);
  logic unused_ctl;
  assign unused_ctl = en_i ^ srst_i;

  always_comb begin
    nxt_o = d_i;
    if (HAS_CE && CE_OVER_SRST && !en_i) nxt_o = q_i;
    else if (HAS_SRST && srst_i)         nxt_o = SRST_VAL;
    else if (HAS_CE && !en_i)            nxt_o = q_i;
  end
endmodule

// File: rtl/ureg_store.sv
module ureg_store
  import ureg_pkg::*;
#(
  parameter int            W         = 8,
  parameter store_kind_e   KIND      = K_FLOP,
  parameter bit            HAS_ARST  = 1'b0,
  parameter bit            HAS_ALOAD = 1'b0,
  parameter bit            HAS_SR    = 1'b0,
  parameter logic [W-1:0]  INIT_VAL  = '0,
  parameter logic [W-1:0]  ARST_VAL  = '0
) (
  input  logic         ck_i,
  input  logic         al_i,
  input  logic [W-1:0] ad_i,
  input  logic         ar_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic unused_in;
  assign unused_in = ^{ck_i, al_i, ad_i, ar_i, set_i, clr_i, nxt_i, d_i};

  if (KIND == K_WIRE) begin : g_wire
    assign q_o = d_i;
  end else if (KIND == K_FLOP) begin : g_flop
    logic [W-1:0] r;
    initial r = INIT_VAL;
    always @(posedge ck_i) r <= nxt_i;
    assign q_o = r;
  end else if (KIND == K_FLOP_AR) begin : g_flop_ar
    logic [W-1:0] r;
    initial r = INIT_VAL;
    always @(posedge ck_i or posedge ar_i) begin
      if (ar_i) r <= ARST_VAL;
      else      r <= nxt_i;
    end
    assign q_o = r;
  end else if (KIND == K_FLOP_AL) begin : g_flop_al
    logic [W-1:0] r;
    initial r = INIT_VAL;
    always @(posedge ck_i or posedge al_i) begin
      if (al_i) r <= ad_i;
      else      r <= nxt_i;
    end
    assign q_o = r;
  end else if (KIND == K_FLOP_SR) begin : g_flop_sr
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic r;
      initial r = INIT_VAL[b];
      always @(posedge ck_i or posedge clr_i[b] or posedge set_i[b]) begin
        if (clr_i[b])      r <= 1'b0;
        else if (set_i[b]) r <= 1'b1;
        else               r <= nxt_i[b];
      end
      assign q_o[b] = r;
    end
  end else begin : g_latch
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic r;
      initial r = INIT_VAL[b];
      always @(*) begin
        if (HAS_SR && clr_i[b])      r = 1'b0;
        else if (HAS_SR && set_i[b]) r = 1'b1;
        else if (HAS_ARST && ar_i)   r = ARST_VAL[b];
        else if (HAS_ALOAD && al_i)  r = ad_i[b];
      end
      assign q_o[b] = r;
    end
  end
endmodule

// File: rtl/ureg_cell.sv
module ureg_cell
  import ureg_pkg::*;
#(
  parameter int                WIDTH        = 8,
  parameter bit                HAS_CLK      = 1'b1,
  parameter bit                HAS_CE       = 1'b1,
  parameter bit                HAS_SRST     = 1'b0,
  parameter bit                HAS_ARST     = 1'b0,
  parameter bit                HAS_ALOAD    = 1'b0,
  parameter bit                HAS_SR       = 1'b1,
  parameter bit                CE_OVER_SRST = 1'b0,
  parameter bit                POL_CLK      = 1'b1,
  parameter bit                POL_CE       = 1'b1,
  parameter bit                POL_ALOAD    = 1'b1,
  parameter bit                POL_ARST     = 1'b1,
  parameter bit                POL_SRST     = 1'b1,
  parameter bit                POL_SET      = 1'b1,
  parameter bit                POL_CLR      = 1'b1,
  parameter logic [WIDTH-1:0]  INIT_VAL     = '0,
  parameter logic [WIDTH-1:0]  ARST_VAL     = '0,
  parameter logic [WIDTH-1:0]  SRST_VAL     = '0
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             aload_i,
  input  logic [WIDTH-1:0] ad_i,
  input  logic             arst_i,
  input  logic             srst_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  localparam bit          LEGAL = cfg_legal(HAS_CLK, HAS_CE, HAS_SRST, HAS_ARST, HAS_ALOAD, HAS_SR);
  localparam store_kind_e KIND  = pick_kind(HAS_CLK, HAS_ARST, HAS_ALOAD, HAS_SR);

  if (!LEGAL) begin : g_illegal
    $error("ureg_cell: illegal combination of feature parameters");
  end

  logic             ck, en, al, ar, srst;
  logic [WIDTH-1:0] set_a, clr_a, nxt;

  ureg_pol #(.W(1),     .ACT_HIGH(POL_CLK))   u_pol_ck  (.raw_i(clk_i),   .act_o(ck));
  ureg_pol #(.W(1),     .ACT_HIGH(POL_CE))    u_pol_en  (.raw_i(en_i),    .act_o(en));
  ureg_pol #(.W(1),     .ACT_HIGH(POL_ALOAD)) u_pol_al  (.raw_i(aload_i), .act_o(al));
  ureg_pol #(.W(1),     .ACT_HIGH(POL_ARST))  u_pol_ar  (.raw_i(arst_i),  .act_o(ar));
  ureg_pol #(.W(1),     .ACT_HIGH(POL_SRST))  u_pol_sr  (.raw_i(srst_i),  .act_o(srst));
  ureg_pol #(.W(WIDTH), .ACT_HIGH(POL_SET))   u_pol_set (.raw_i(set_i),   .act_o(set_a));
  ureg_pol #(.W(WIDTH), .ACT_HIGH(POL_CLR))   u_pol_clr (.raw_i(clr_i),   .act_o(clr_a));

  ureg_next #(
    .W(WIDTH), .HAS_CE(HAS_CE), .HAS_SRST(HAS_SRST),
    .CE_OVER_SRST(CE_OVER_SRST), .SRST_VAL(SRST_VAL)
  ) u_next (
    .q_i(q_o), .d_i(d_i), .en_i(en), .srst_i(srst), .nxt_o(nxt)
  );

  ureg_store #(
    .W(WIDTH), .KIND(KIND), .HAS_ARST(HAS_ARST), .HAS_ALOAD(HAS_ALOAD),
    .HAS_SR(HAS_SR), .INIT_VAL(INIT_VAL), .ARST_VAL(ARST_VAL)
  ) u_store (
    .ck_i(ck), .al_i(al), .ad_i(ad_i), .ar_i(ar), .set_i(set_a),
    .clr_i(clr_a), .nxt_i(nxt), .d_i(d_i), .q_o(q_o)
  );
endmodule

// File: rtl/ureg_cell_chk.sv
module ureg_cell_chk #(
  parameter int                WIDTH        = 8,
  parameter bit                HAS_CLK      = 1'b1,
  parameter bit                HAS_CE       = 1'b1,
  parameter bit                HAS_SRST     = 1'b0,
  parameter bit                HAS_ARST     = 1'b0,
  parameter bit                HAS_ALOAD    = 1'b0,
  parameter bit                HAS_SR       = 1'b1,
  parameter bit                CE_OVER_SRST = 1'b0,
  parameter bit                POL_CLK      = 1'b1,
  parameter bit                POL_CE       = 1'b1,
  parameter bit                POL_ALOAD    = 1'b1,
  parameter bit                POL_ARST     = 1'b1,
  parameter bit                POL_SRST     = 1'b1,
  parameter bit                POL_SET      = 1'b1,
  parameter bit                POL_CLR      = 1'b1,
  parameter logic [WIDTH-1:0]  ARST_VAL     = '0,
  parameter logic [WIDTH-1:0]  SRST_VAL     = '0
) (
  input logic             clk_i,
  input logic             en_i,
  input logic [WIDTH-1:0] d_i,
  input logic             aload_i,
  input logic [WIDTH-1:0] ad_i,
  input logic             arst_i,
  input logic             srst_i,
  input logic [WIDTH-1:0] set_i,
  input logic [WIDTH-1:0] clr_i,
  input logic [WIDTH-1:0] q_o
);
  logic             ck, en_a, al_a, ar_a, sr_a, async_any;
  logic [WIDTH-1:0] st_a, cl_a;
  logic             armed, touched;

  assign ck    = POL_CLK ? clk_i : ~clk_i;
  assign en_a  = POL_CE ? en_i : ~en_i;
  assign al_a  = HAS_ALOAD && (POL_ALOAD ? aload_i : ~aload_i);
  assign ar_a  = HAS_ARST && (POL_ARST ? arst_i : ~arst_i);
  assign sr_a  = HAS_SRST && (POL_SRST ? srst_i : ~srst_i);
  assign st_a  = HAS_SR ? (POL_SET ? set_i : ~set_i) : '0;
  assign cl_a  = HAS_SR ? (POL_CLR ? clr_i : ~clr_i) : '0;
  assign async_any = al_a || ar_a || (|st_a) || (|cl_a);

  initial armed = 1'b0;
  always @(posedge ck) armed <= 1'b1;

  // Marks a cycle in which any asynchronous control was active.
  initial touched = 1'b0;
  always @(posedge ck or posedge async_any) begin
    if (async_any) touched <= 1'b1;
    else           touched <= 1'b0;
  end

  // R2
  clear_wins_chk: assert property (@(posedge ck) disable iff (!armed)
    (|cl_a) |-> ((q_o & cl_a) == '0));

  // R3
  set_bits_chk: assert property (@(posedge ck) disable iff (!armed)
    (|st_a) |-> (((st_a & ~cl_a) & ~q_o) == '0));

  // R4
  arst_value_chk: assert property (@(posedge ck) disable iff (!armed)
    (ar_a && cl_a == '0 && st_a == '0) |-> (q_o == ARST_VAL));

  // R5
  aload_copy_chk: assert property (@(posedge ck) disable iff (!armed)
    (al_a && !ar_a && cl_a == '0 && st_a == '0) |-> (q_o == ad_i));

  if (HAS_CLK) begin : g_sync
    // R6
    capture_chk: assert property (@(posedge ck) disable iff (!armed)
      ((!HAS_CE || en_a) && !sr_a && !async_any)
      |=> (touched || async_any || q_o == $past(d_i)));

    if (HAS_CE) begin : g_ce
      // R7
      hold_chk: assert property (@(posedge ck) disable iff (!armed)
        (!en_a && !(sr_a && !CE_OVER_SRST) && !async_any)
        |=> (touched || async_any || $stable(q_o)));
    end

    if (HAS_SRST) begin : g_srst
      // R8 R9
      srst_load_chk: assert property (@(posedge ck) disable iff (!armed)
        (sr_a && (!HAS_CE || !CE_OVER_SRST || en_a) && !async_any)
        |=> (touched || async_any || q_o == SRST_VAL));
    end
  end
endmodule

bind ureg_cell ureg_cell_chk #(
  .WIDTH(WIDTH), .HAS_CLK(HAS_CLK), .HAS_CE(HAS_CE), .HAS_SRST(HAS_SRST),
  .HAS_ARST(HAS_ARST), .HAS_ALOAD(HAS_ALOAD), .HAS_SR(HAS_SR),
  .CE_OVER_SRST(CE_OVER_SRST), .POL_CLK(POL_CLK), .POL_CE(POL_CE),
  .POL_ALOAD(POL_ALOAD), .POL_ARST(POL_ARST), .POL_SRST(POL_SRST),
  .POL_SET(POL_SET), .POL_CLR(POL_CLR), .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL)
) i_chk (.*);

// File: tb/test_ureg_cell.sv
module test_ureg_cell;

  typedef struct packed {
    bit       clk, ce, srst, arst, aload, sr, ce_over;
    bit [7:0] arst_v, srst_v, init_v;
  } cfg_t;

  typedef struct packed {
    bit       en, al, ar, sr;
    bit [7:0] d, ad, st, cl;
  } in_t;

  localparam cfg_t C_A = '{clk:1, ce:1, sr:1, init_v:8'h5A, default:0};
  localparam cfg_t C_B = '{clk:1, ce:1, srst:1, srst_v:8'hC3, default:0};
  localparam cfg_t C_C = '{clk:1, ce:1, srst:1, ce_over:1, srst_v:8'h96, init_v:8'hFF, default:0};
  localparam cfg_t C_D = '{clk:1, arst:1, arst_v:8'h3C, init_v:8'h11, default:0};
  localparam cfg_t C_E = '{clk:1, aload:1, init_v:8'h22, default:0};
  localparam cfg_t C_F = '{aload:1, arst:1, arst_v:8'hE1, init_v:8'h33, default:0};
  localparam cfg_t C_G = '{arst:1, arst_v:8'h7E, init_v:8'h44, default:0};
  localparam cfg_t C_H = '{default:0};

  logic       clk = 1'b0;
  logic       en = 1'b0, al = 1'b0, ar = 1'b0, sr = 1'b0;
  logic [7:0] d = '0, ad = '0, st = '0, cl = '0;
  logic [7:0] q_obs [8];
  logic [7:0] expv  [8];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // A: clock, enable, per-bit set/clear (the default configuration)
  ureg_cell #(.INIT_VAL(C_A.init_v)) i_ureg_cell (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[0]));

  // B: falling-edge clock, active-low enable and sync reset (R10), reset ignores enable
  ureg_cell #(.HAS_SR(1'b0), .HAS_SRST(1'b1), .POL_CLK(1'b0), .POL_CE(1'b0),
    .POL_SRST(1'b0), .SRST_VAL(C_B.srst_v), .INIT_VAL(C_B.init_v)) u_b (
    .clk_i(~clk), .en_i(~en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(~sr), .set_i(st), .clr_i(cl), .q_o(q_obs[1]));

  // C: enable gates sync reset
  ureg_cell #(.HAS_SR(1'b0), .HAS_SRST(1'b1), .CE_OVER_SRST(1'b1),
    .SRST_VAL(C_C.srst_v), .INIT_VAL(C_C.init_v)) u_c (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[2]));

  // D: clock with active-low async reset
  ureg_cell #(.HAS_CE(1'b0), .HAS_SR(1'b0), .HAS_ARST(1'b1), .POL_ARST(1'b0),
    .ARST_VAL(C_D.arst_v), .INIT_VAL(C_D.init_v)) u_d (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(~ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[3]));

  // E: clock with async load
  ureg_cell #(.HAS_CE(1'b0), .HAS_SR(1'b0), .HAS_ALOAD(1'b1), .INIT_VAL(C_E.init_v)) u_e (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[4]));

  // F: latch with reset
  ureg_cell #(.HAS_CLK(1'b0), .HAS_CE(1'b0), .HAS_SR(1'b0), .HAS_ALOAD(1'b1),
    .HAS_ARST(1'b1), .ARST_VAL(C_F.arst_v), .INIT_VAL(C_F.init_v)) u_f (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[5]));

  // G: async reset only
  ureg_cell #(.HAS_CLK(1'b0), .HAS_CE(1'b0), .HAS_SR(1'b0), .HAS_ARST(1'b1),
    .ARST_VAL(C_G.arst_v), .INIT_VAL(C_G.init_v)) u_g (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[6]));

  // H: no features
  ureg_cell #(.HAS_CLK(1'b0), .HAS_CE(1'b0), .HAS_SR(1'b0)) u_h (
    .clk_i(clk), .en_i(en), .d_i(d), .aload_i(al), .ad_i(ad), .arst_i(ar),
    .srst_i(sr), .set_i(st), .clr_i(cl), .q_o(q_obs[7]));

  function automatic cfg_t cfg_of(int i);
    case (i)
      0: return C_A;  1: return C_B;  2: return C_C;  3: return C_D;
      4: return C_E;  5: return C_F;  6: return C_G;  default: return C_H;
    endcase
  endfunction

  // Level effects of the asynchronous controls, lowest rank first.
  function automatic logic [7:0] lvl(cfg_t c, logic [7:0] q, in_t x);
    logic [7:0] r;
    r = q;
    if (!(c.clk || c.arst || c.aload || c.sr)) return x.d;
    if (c.aload && x.al) r = x.ad;
    if (c.arst && x.ar)  r = c.arst_v;
    if (c.sr)            r = (r | x.st) & ~x.cl;
    return r;
  endfunction

  function automatic logic [7:0] at_edge(cfg_t c, logic [7:0] q, in_t x);
    logic [7:0] r;
    r = q;
    if (c.clk && !((c.aload && x.al) || (c.arst && x.ar))) begin
      if (c.ce && c.ce_over && !x.en) r = q;
      else if (c.srst && x.sr)        r = c.srst_v;
      else if (c.ce && !x.en)         r = q;
      else                            r = x.d;
    end
    return lvl(c, r, x);
  endfunction

  task automatic check_all(string tag, string phase);
    for (int i = 0; i < 8; i++) begin
      total++;
      if (q_obs[i] !== expv[i]) begin
        bad++;
        // the pass-through unit (7) always covers R12
        $display("FAIL %s (%s) unit %0d: actual %h expected %h",
                 (i == 7) ? "R12" : tag, phase, i, q_obs[i], expv[i]);
      end
    end
  endtask

  task automatic step(string tag, in_t x);
    en = x.en; d = x.d; ad = x.ad; al = x.al; ar = x.ar; sr = x.sr; st = x.st; cl = x.cl;
    #4;
    for (int i = 0; i < 8; i++) expv[i] = lvl(cfg_of(i), expv[i], x);
    check_all(tag, "level");
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) expv[i] = at_edge(cfg_of(i), expv[i], x);
    check_all(tag, "edge");
  endtask

  initial begin
    in_t z;
    z = '{default:0};
    #1;
    for (int i = 0; i < 8; i++) expv[i] = lvl(cfg_of(i), cfg_of(i).init_v, z);
    check_all("R1", "init");
    @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) expv[i] = at_edge(cfg_of(i), expv[i], z);
    check_all("R6", "edge");

    step("R6 R10",   '{en:1, d:8'hA5, default:0});
    step("R6",       '{en:1, d:8'h3C, default:0});
    step("R7",       '{en:0, d:8'hFF, default:0});
    step("R8 R9 R10",'{en:0, sr:1, d:8'hFF, default:0});
    step("R8 R9",    '{en:1, sr:1, d:8'h11, default:0});
    step("R2 R3",    '{en:1, d:8'h0F, st:8'hFF, cl:8'h0F, default:0});
    step("R2",       '{en:1, d:8'h0F, cl:8'h0F, default:0});
    step("R2 R6",    '{en:1, d:8'h66, default:0});
    step("R3 R7",    '{en:0, d:8'h00, st:8'h81, default:0});
    step("R4 R10 R11",'{en:1, d:8'h77, ar:1, al:1, ad:8'h5A, default:0});
    step("R4 R5 R11",'{en:1, d:8'h77, al:1, ad:8'h5A, default:0});
    step("R5 R6",    '{en:1, d:8'h12, ad:8'h5A, default:0});
    step("R5",       '{en:1, d:8'h12, al:1, ad:8'h99, default:0});
    step("R5 R6",    '{en:1, d:8'hC3, ad:8'h44, default:0});
    step("R6 R12",   '{en:1, d:8'h3C, default:0});
    step("R7 R9",    '{en:0, sr:1, d:8'h5E, default:0});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule